// File: doc/BRIEF.md
# Integer ALU with Condition Codes

This block is the integer execute stage of a 32-bit core. It computes add, add with carry-in, subtract, subtract with borrow-in and six bitwise operations: plain and, or and xor, and each of them with the second operand complemented first. The result is combinational. A small register holds four condition flags: negative, zero, overflow and carry.

The first operand always comes from a register value. The second operand is either a register value or a 13-bit signed immediate, which is sign-extended to 32 bits. Each operation can run in one of two forms. One form writes the flags at the next clock edge. The other form leaves the flags alone. The carry-using forms read the stored carry flag. The design also puts out the flag value that the register will hold after the coming edge.

Common idioms map directly onto these operations. Subtracting a register from zero gives the two's complement. Xnor with zero gives the one's complement. A bit test is a flag-setting and whose result is discarded. Bit set, clear and toggle are or, and-with-complement and xor.

Top module: `int_alu_cc`

## Requirements
- R1: After reset the stored flags `nzvc_q` are 0000. The bit order is N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.
- R2: When `use_imm` is 1, operand B is `imm13` with bit 12 copied into bits 31:13. When `use_imm` is 0, operand B is `rs2_val`.
- R3: Operation code 0 (add) gives A+B. Code 1 (add with carry) gives A+B+C, where C is the stored carry flag. For both, the computed C is the carry out of bit 31 and V is signed overflow.
- R4: Operation code 2 (subtract) gives A-B. Code 3 (subtract with borrow) gives A-B-C. For both, the computed C is 1 when unsigned A is less than B plus the borrow-in, and V is signed overflow.
- R5: The logic codes give these results: 4 is A&B, 5 is A&~B, 6 is A|B, 7 is A|~B, 8 is A^B and 9 is A^~B.
- R6: For every flag-setting operation, the computed N is bit 31 of the result and the computed Z is 1 exactly when the result is zero.
- R7: Flag-setting logic operations (codes 4 to 9) give V=0 and C=0.
- R8: The flags change at a clock edge only when `op_valid`=1, `set_flags`=1 and the code is 0 to 9. In every other case they hold their value.
- R9: Codes 10 to 15 give result 0 and never change the flags.
- R10: `nzvc_next` always equals the value that `nzvc_q` takes at the next clock edge.
- R11: The carry-using codes read the carry flag that was stored before the edge, even when the same operation writes the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code, 0 to 9 |
| set_flags | input | 1 | Write the flags from this operation |
| use_imm | input | 1 | Select the immediate as operand B |
| rs1_val | input | 32 | Operand A |
| rs2_val | input | 32 | Register operand B |
| imm13 | input | 13 | Signed immediate operand |
| result | output | 32 | Combinational result |
| nzvc_next | output | 4 | Flag value after the coming edge |
| nzvc_q | output | 4 | Stored flags {N,Z,V,C} |

## Verification
The clocked properties assume that `op_sel`, `op_valid` and `set_flags` are stable and known at each rising edge. The stimulus meets this by changing every input only on the falling edge. The immediate check assumes `imm13` is fully driven whenever `use_imm` is high, and the bench never leaves it undriven. The stimulus mixes corner operands (zero, all ones, and the signed extremes) with random values, and it sweeps every code including the unused codes 10 to 15. This covers carry, borrow and overflow in both directions.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int XLEN  = 32;
    localparam int IMM_W = 13;
    localparam int OP_W  = 4;

    localparam logic [OP_W-1:0] OP_ADD  = 4'd0;
    localparam logic [OP_W-1:0] OP_ADDC = 4'd1;
    localparam logic [OP_W-1:0] OP_SUB  = 4'd2;
    localparam logic [OP_W-1:0] OP_SUBC = 4'd3;
    localparam logic [OP_W-1:0] OP_AND  = 4'd4;
    localparam logic [OP_W-1:0] OP_ANDN = 4'd5;
    localparam logic [OP_W-1:0] OP_OR   = 4'd6;
    localparam logic [OP_W-1:0] OP_ORN  = 4'd7;
    localparam logic [OP_W-1:0] OP_XOR  = 4'd8;
    localparam logic [OP_W-1:0] OP_XNOR = 4'd9;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

    function automatic logic op_is_legal(input logic [OP_W-1:0] op);
        return op <= OP_XNOR;
    endfunction

    function automatic logic op_is_logic(input logic [OP_W-1:0] op);
        return (op >= OP_AND) && (op <= OP_XNOR);
    endfunction
endpackage

// File: rtl/alu_opnd.sv
module alu_opnd #(
    parameter int W  = 32,
    parameter int IW = 13
) (
    input  logic          use_imm,
    input  logic [W-1:0]  rs2_val,
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  opb
);
    localparam int EXT_W = W - IW;

    logic [W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm[IW-1]}}, imm};
        opb     = use_imm ? imm_ext : rs2_val;
    end

    // R2
    always_comb begin
        if (use_imm) begin
            imm_sext_chk: assert (($countones(opb[W-1:IW-1]) == 0) ||
                                  ($countones(opb[W-1:IW-1]) == EXT_W + 1));
        end
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            c_out,
    output logic            v_out
);
    logic         is_sub;
    logic         use_c;
    logic [W-1:0] b_eff;
    logic         ci;
    logic [W:0]   sum;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SUBC);
        use_c  = (op == OP_ADDC) || (op == OP_SUBC);
        b_eff  = is_sub ? ~b : b;
        if (is_sub) ci = use_c ? ~cin : 1'b1;
        else        ci = use_c ? cin : 1'b0;
        sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci};
        res    = sum[W-1:0];
        c_out  = is_sub ? ~sum[W] : sum[W];
        v_out  = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    res
);
    logic         inv_b;
    logic [W-1:0] and_v;
    logic [W-1:0] or_v;
    logic [W-1:0] xor_v;

    assign inv_b = (op == OP_ANDN) || (op == OP_ORN) || (op == OP_XNOR);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bm;
        assign bm       = b[i] ^ inv_b;
        assign and_v[i] = a[i] & bm;
        assign or_v[i]  = a[i] | bm;
        assign xor_v[i] = a[i] ^ bm;
    end

    always_comb begin
        unique case (op)
            OP_AND, OP_ANDN: res = and_v;
            OP_OR,  OP_ORN:  res = or_v;
            OP_XOR, OP_XNOR: res = xor_v;
            default:         res = '0;
        endcase
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic         is_logic,
    input  logic [W-1:0] res,
    input  logic         c_in,
    input  logic         v_in,
    output nzvc_t        nzvc_d,
    output nzvc_t        nzvc_q
);
    always_comb begin
        nzvc_d = nzvc_q;
        if (upd) begin
            nzvc_d.n = res[W-1];
            nzvc_d.z = (res == '0);
            nzvc_d.v = is_logic ? 1'b0 : v_in;
            nzvc_d.c = is_logic ? 1'b0 : c_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nzvc_q <= '0;
        else        nzvc_q <= nzvc_d;
    end

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> nzvc_q == $past(nzvc_q));

    // R10
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> nzvc_q == $past(nzvc_d));
endmodule

// File: rtl/int_alu_cc.sv
module int_alu_cc
    import alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_sel,
    input  logic            set_flags,
    input  logic            use_imm,
    input  logic [W-1:0]    rs1_val,
    input  logic [W-1:0]    rs2_val,
    input  logic [IW-1:0]   imm13,
    output logic [W-1:0]    result,
    output logic [3:0]      nzvc_next,
    output logic [3:0]      nzvc_q
);
    logic [W-1:0] opb;
    logic [W-1:0] ar_res;
    logic [W-1:0] lg_res;
    logic         ar_c;
    logic         ar_v;
    logic         legal;
    logic         is_logic;
    logic         upd;
    nzvc_t        flags_d;
    nzvc_t        flags_q;

    alu_opnd #(.W(W), .IW(IW)) u_opnd (
        .use_imm (use_imm),
        .rs2_val (rs2_val),
        .imm     (imm13),
        .opb     (opb)
    );

    alu_arith #(.W(W)) u_arith (
        .op    (op_sel),
        .a     (rs1_val),
        .b     (opb),
        .cin   (flags_q.c),
        .res   (ar_res),
        .c_out (ar_c),
        .v_out (ar_v)
    );

    alu_logic #(.W(W)) u_logic (
        .op  (op_sel),
        .a   (rs1_val),
        .b   (opb),
        .res (lg_res)
    );

    always_comb begin
        legal    = op_is_legal(op_sel);
        is_logic = op_is_logic(op_sel);
        upd      = op_valid && set_flags && legal;
        if (!legal)        result = '0;
        else if (is_logic) result = lg_res;
        else               result = ar_res;
    end

    alu_flags #(.W(W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .is_logic (is_logic),
        .res      (result),
        .c_in     (ar_c),
        .v_in     (ar_v),
        .nzvc_d   (flags_d),
        .nzvc_q   (flags_q)
    );

    assign nzvc_next = flags_d;
    assign nzvc_q    = flags_q;

    // R7
    logic_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && set_flags && is_logic) |-> (!flags_d.v && !flags_d.c));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (flags_d.z == (result == '0)) && (flags_d.n == result[W-1]));

    // R9
    illegal_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> (result == '0) && (flags_d == flags_q));
endmodule

// File: tb/sim_int_alu_cc.sv
module sim_int_alu_cc;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        set_flags = 1'b0;
    logic        use_imm = 1'b0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [12:0] imm13 = '0;
    logic [31:0] result;
    logic [3:0]  nzvc_next;
    logic [3:0]  nzvc_q;

    int total = 0;
    int fails = 0;
    logic [3:0] mflags = 4'b0000;

    always #(CLK_P/2) clk = ~clk;

    int_alu_cc u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .set_flags(set_flags), .use_imm(use_imm), .rs1_val(rs1_val),
        .rs2_val(rs2_val), .imm13(imm13), .result(result),
        .nzvc_next(nzvc_next), .nzvc_q(nzvc_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h op=%0d", tag, act, exp, op_sel);
        end
    endtask

    function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                  input logic [3:0] fq, input logic upd,
                                  output logic [31:0] r, output logic [3:0] fn);
        longint ua, ub, ci, su, ss;
        logic vv, cc, ok;
        ua = longint'(a);
        ub = longint'(b);
        ci = fq[0] ? 64'sd1 : 64'sd0;
        vv = 1'b0; cc = 1'b0; ok = 1'b1; su = 0; ss = 0;
        case (op)
            4'd0, 4'd1: begin
                su = ua + ub + ((op == 4'd1) ? ci : 0);
                ss = longint'($signed(a)) + longint'($signed(b)) + ((op == 4'd1) ? ci : 0);
                r  = su[31:0];
                cc = su >= 64'sd4294967296;
            end
            4'd2, 4'd3: begin
                su = ua - ub - ((op == 4'd3) ? ci : 0);
                ss = longint'($signed(a)) - longint'($signed(b)) - ((op == 4'd3) ? ci : 0);
                r  = su[31:0];
                cc = ua < ub + ((op == 4'd3) ? ci : 0);
            end
            4'd4: r = a & b;
            4'd5: r = a & ~b;
            4'd6: r = a | b;
            4'd7: r = a | ~b;
            4'd8: r = a ^ b;
            4'd9: r = a ^ ~b;
            default: begin r = '0; ok = 1'b0; end
        endcase
        if (op <= 4'd3) vv = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        fn = (ok && upd) ? {r[31], r == 32'd0, vv, cc} : fq;
    endfunction

    task automatic apply(input logic v, input logic [3:0] op, input logic sf, input logic ui,
                         input logic [31:0] a, input logic [31:0] b, input logic [12:0] im);
        logic [31:0] eb, er;
        logic [3:0]  ef;
        string rt, ft;
        op_valid = v; op_sel = op; set_flags = sf; use_imm = ui;
        rs1_val = a; rs2_val = b; imm13 = im;
        #1;
        eb = ui ? 32'($signed(im)) : b;
        model(op, a, eb, mflags, v && sf, er, ef);
        if (op > 4'd9)      rt = "R9";
        else if (ui)        rt = "R2";
        else if (op <= 4'd1) rt = "R3";
        else if (op <= 4'd3) rt = "R4";
        else                rt = "R5";
        if (!(v && sf) || op > 4'd9) ft = "R8";
        else if (op >= 4'd4)         ft = "R7";
        else if (op == 4'd1 || op == 4'd3) ft = "R11";
        else                         ft = "R6";
        chk(rt, result, er);
        chk(ft, {28'd0, nzvc_next}, {28'd0, ef});
        chk("R10", {28'd0, nzvc_q}, {28'd0, mflags});
        @(posedge clk);
        mflags = ef;
        @(negedge clk);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(CLK_P * 150000);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {28'd0, nzvc_q}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: signed overflow and carry out
        apply(1, 4'd0, 1, 0, 32'h7FFF_FFFF, 32'd1, 13'd0);
        apply(1, 4'd0, 1, 0, 32'hFFFF_FFFF, 32'd1, 13'd0);
        // R11: add with carry reads the stored carry
        apply(1, 4'd1, 1, 0, 32'd5, 32'd6, 13'd0);
        // R4: two's complement from zero, borrow
        apply(1, 4'd2, 1, 0, 32'd0, 32'd7, 13'd0);
        apply(1, 4'd3, 1, 0, 32'd7, 32'd6, 13'd0);
        apply(1, 4'd2, 1, 0, 32'h8000_0000, 32'd1, 13'd0);
        // R5: one's complement via xnor with zero, bit test via and
        apply(1, 4'd9, 1, 0, 32'h1234_5678, 32'd0, 13'd0);
        apply(1, 4'd4, 1, 1, 32'h0000_0008, 32'd0, 13'd8);
        // R2: negative immediate
        apply(1, 4'd0, 1, 1, 32'd10, 32'hDEAD_BEEF, 13'h1FFF);
        apply(1, 4'd6, 0, 1, 32'd0, 32'd0, 13'h1000);
        // R8: valid low / no-set variant hold flags
        apply(0, 4'd2, 1, 0, 32'd0, 32'd1, 13'd0);
        apply(1, 4'd2, 0, 0, 32'd0, 32'd1, 13'd0);
        // R9: unused codes
        for (int k = 10; k < 16; k++) apply(1, 4'(k), 1, 0, 32'd3, 32'd4, 13'd0);
        for (int i = 0; i < 4000; i++) begin
            apply($urandom_range(0, 7) != 0, 4'($urandom_range(0, 11)), 1'($urandom),
                  1'($urandom), pick(), pick(), 13'($urandom));
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule